// File: doc/BRIEF.md
# Coprocessor Mailbox and Control Register Block

This block is the host-facing register file for a small embedded controller that sits next to a host CPU. The host reaches it through a plain 32-bit register port with a write strobe and a combinational read path. Through it the host holds the controller in reset or lets it run, rings a doorbell to post a command, reads and clears a status word that carries the controller's interrupt cause, arms a watchdog, selects the tightly coupled memory split, and samples the controller's program counter.

The controller side is a handful of wires. It acknowledges a doorbell with a one-cycle pulse, holds a message request high until the status word takes it, kicks the watchdog, and presents its current program counter. A single level interrupt goes to the host for as long as the status word is nonzero. While the word is occupied, new causes from the controller or the watchdog are refused, so the host sees exactly one cause per interrupt and re-arms the path by writing zero.

The watchdog is a down-counter reloaded from the low bits of its own register. It counts only while the controller is out of reset and the enable bit is set, restarts on each kick, and on reaching zero posts a watchdog cause if the status word is free.

Top module: `cop_mailbox_regs`

## Requirements
- R1: After reset the run bit reads 0 and `cop_rst_n` is low, the doorbell and status read 0, `host_irq` is low, the memory split register reads 2 (the 96 KB program / 32 KB data split), and the watchdog register reads 0x0000_0040 (enable clear, reload 64).
- R2: Bit 0 of the control register at offset 0x00 is the run bit; it is writable, reads back as written (other bits read 0), and drives `cop_rst_n`.
- R3: A host write with bit 0 set to the doorbell at offset 0x24 makes it read 1 on the next cycle while running; a write with bit 0 clear has no effect; only a `cop_ack` pulse returns it to 0.
- R4: While the run bit is 0 the doorbell is forced to 0 and cannot be set, message requests are not taken, and the watchdog does not count.
- R5: With the status word at offset 0x1C equal to zero and the controller running, a high `cop_msg_req` loads 0x0000_0100 (bit 8 set) on the next edge; a message request wins over a watchdog expiry in the same cycle.
- R6: While the status word is nonzero, message requests and watchdog expiries leave it unchanged; a host write replaces its value, and writing 0 lets the next cause in.
- R7: `host_irq` is high exactly while the status word is nonzero.
- R8: All 32 bits of the watchdog register at offset 0x84 are writable and read back unchanged; bit 31 enables the counter and the low WDOG_W bits give the reload value L.
- R9: Once enabled with reload L while running, with no kick, the status word becomes 0x0000_0001 (bit 8 clear) on the (L+1)-th clock edge after the enabling write and stays 0 before it; a `cop_wdt_kick` restarts the count from L.
- R10: Offset 0x60 reads `cop_pc`, and host writes there have no effect.
- R11: The low 4 bits of the memory split register at offset 0x08 are writable, read back and drive `tcm_cfg`; upper bits read 0; unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host write strobe for one cycle |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for `h_addr`, combinational |
| host_irq | output | 1 | Level interrupt to the host |
| cop_rst_n | output | 1 | Low holds the controller in reset |
| db_pending | output | 1 | Doorbell state seen by the controller |
| stat_busy | output | 1 | Status word occupied; controller keeps its request held |
| tcm_cfg | output | 4 | Memory split selection |
| cop_ack | input | 1 | Controller doorbell acknowledge pulse |
| cop_msg_req | input | 1 | Controller message interrupt request, held until taken |
| cop_wdt_kick | input | 1 | Controller watchdog kick pulse |
| cop_pc | input | 32 | Controller program counter |

## Verification
The hardest state to reach is the status word already holding a watchdog cause while a message request and a second expiry both arrive, since an expiry only occurs after an exact count of enabled cycles. The stimulus programs a short reload, enables the counter, counts edges to the predicted expiry, then pulses a message request and waits past another full period to show neither disturbs the word. It then disables the counter and clears the word to show no deferred cause surfaces, and separately shows that a doorbell posted just before dropping the run bit is wiped.

// File: rtl/cop_mailbox_regs.sv
module cop_mailbox_regs #(
  parameter int ADDR_W = 8,
  parameter int WDOG_W = 16,
  parameter logic [WDOG_W-1:0] WDOG_RELOAD_RST = 64,
  parameter int TCM_W = 4,
  parameter logic [TCM_W-1:0] TCM_CFG_RST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  output logic              host_irq,
  output logic              cop_rst_n,
  output logic              db_pending,
  output logic              stat_busy,
  output logic [TCM_W-1:0]  tcm_cfg,
  input  logic              cop_ack,
  input  logic              cop_msg_req,
  input  logic              cop_wdt_kick,
  input  logic [31:0]       cop_pc
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_TCM  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_DB   = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_PC   = ADDR_W'(8'h60);
  localparam logic [ADDR_W-1:0] A_WDT  = ADDR_W'(8'h84);
  localparam logic [31:0] MSG_CODE = 32'h0000_0100;
  localparam logic [31:0] WDT_CODE = 32'h0000_0001;
  localparam int WDT_EN_BIT = 31;

  logic              run_q;
  logic              db_q;
  logic [TCM_W-1:0]  tcm_q;
  logic [31:0]       stat_q;
  logic [31:0]       wdt_q;
  logic [WDOG_W-1:0] cnt_q;

  wire wr_ctrl = h_we && (h_addr == A_CTRL);
  wire wr_tcm  = h_we && (h_addr == A_TCM);
  wire wr_stat = h_we && (h_addr == A_STAT);
  wire wr_db   = h_we && (h_addr == A_DB);
  wire wr_wdt  = h_we && (h_addr == A_WDT);

  wire [WDOG_W-1:0] reload = wdt_q[WDOG_W-1:0];
  wire wdt_active = run_q && wdt_q[WDT_EN_BIT];
  wire wdt_expire = wdt_active && !cop_wdt_kick && (cnt_q == '0);
  wire stat_idle  = (stat_q == '0);
  wire msg_take   = stat_idle && run_q && cop_msg_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      tcm_q <= TCM_CFG_RST;
      wdt_q <= {{(32-WDOG_W){1'b0}}, WDOG_RELOAD_RST};
    end else begin
      if (wr_ctrl) run_q <= h_wdata[0];
      if (wr_tcm)  tcm_q <= h_wdata[TCM_W-1:0];
      if (wr_wdt)  wdt_q <= h_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   db_q <= 1'b0;
    else if (!run_q)              db_q <= 1'b0;
    else if (wr_db && h_wdata[0]) db_q <= 1'b1;
    else if (cop_ack)             db_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       stat_q <= '0;
    else if (wr_stat)                 stat_q <= h_wdata;
    else if (msg_take)                stat_q <= MSG_CODE;
    else if (stat_idle && wdt_expire) stat_q <= WDT_CODE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                        cnt_q <= WDOG_RELOAD_RST;
    else if (!wdt_active || cop_wdt_kick || cnt_q == '0) cnt_q <= reload;
    else                                               cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    case (h_addr)
      A_CTRL:  h_rdata = {31'b0, run_q};
      A_TCM:   h_rdata = {{(32-TCM_W){1'b0}}, tcm_q};
      A_STAT:  h_rdata = stat_q;
      A_DB:    h_rdata = {31'b0, db_q};
      A_PC:    h_rdata = cop_pc;
      A_WDT:   h_rdata = wdt_q;
      default: h_rdata = '0;
    endcase
  end

  assign host_irq   = !stat_idle;
  assign stat_busy  = !stat_idle;
  assign cop_rst_n  = run_q;
  assign db_pending = db_q;
  assign tcm_cfg    = tcm_q;

  AST_DB_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && db_q && !cop_ack) |=> db_q); // R3
  AST_DB_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !db_q); // R4
  AST_HALT_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && stat_idle && !wr_stat) |=> (stat_q == '0)); // R4
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_idle && !wr_stat) |=> $stable(stat_q)); // R6
  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_idle && !wr_stat) |=> (stat_q == '0 || stat_q == MSG_CODE || stat_q == WDT_CODE)); // R5
  AST_WDT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_active && stat_idle && !wr_stat && !(run_q && cop_msg_req)) |=> (stat_q == '0)); // R9

endmodule

// File: tb/tb_cop_mailbox_regs.sv
module tb_cop_mailbox_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_we = 1'b0;
  logic [7:0]  h_addr = 8'h00;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        host_irq, cop_rst_n, db_pending, stat_busy;
  logic [3:0]  tcm_cfg;
  logic        cop_ack = 1'b0, cop_msg_req = 1'b0, cop_wdt_kick = 1'b0;
  logic [31:0] cop_pc = 32'h0001_2340;
  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cop_mailbox_regs dut (
    .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .host_irq(host_irq), .cop_rst_n(cop_rst_n),
    .db_pending(db_pending), .stat_busy(stat_busy), .tcm_cfg(tcm_cfg),
    .cop_ack(cop_ack), .cop_msg_req(cop_msg_req), .cop_wdt_kick(cop_wdt_kick),
    .cop_pc(cop_pc)
  );

  localparam logic [7:0] O_CTRL = 8'h00, O_TCM = 8'h08, O_STAT = 8'h1C,
                         O_DB = 8'h24, O_PC = 8'h60, O_WDT = 8'h84;

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, O_CTRL, 32'h0, 32'h0000_0000, 4'd1},  // R1
    '{1'b0, O_TCM,  32'h0, 32'h0000_0002, 4'd1},
    '{1'b0, O_DB,   32'h0, 32'h0000_0000, 4'd1},
    '{1'b0, O_STAT, 32'h0, 32'h0000_0000, 4'd1},
    '{1'b0, O_WDT,  32'h0, 32'h0000_0040, 4'd1},
    '{1'b1, O_PC,   32'hFFFF_FFFF, 32'h0, 4'd10}, // R10
    '{1'b0, O_PC,   32'h0, 32'h0001_2340, 4'd10},
    '{1'b1, O_TCM,  32'hFFFF_FFF5, 32'h0, 4'd11}, // R11
    '{1'b0, O_TCM,  32'h0, 32'h0000_0005, 4'd11},
    '{1'b0, 8'h44,  32'h0, 32'h0000_0000, 4'd11},
    '{1'b1, O_DB,   32'h1, 32'h0, 4'd4},          // R4
    '{1'b0, O_DB,   32'h0, 32'h0000_0000, 4'd4},
    '{1'b1, O_CTRL, 32'hFFFF_FFFF, 32'h0, 4'd2},  // R2
    '{1'b0, O_CTRL, 32'h0, 32'h0000_0001, 4'd2},
    '{1'b1, O_DB,   32'h1, 32'h0, 4'd3},          // R3
    '{1'b0, O_DB,   32'h0, 32'h0000_0001, 4'd3},
    '{1'b1, O_WDT,  32'h1234_0010, 32'h0, 4'd8}   // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    h_we = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    h_addr = a;
    #1;
    chk(req, h_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run incomplete, got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 cop_rst_n", {31'b0, cop_rst_n}, 32'h0);
    chk("R1 host_irq", {31'b0, host_irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
      else rd(VEC[i].a, VEC[i].e, $sformatf("R%0d table %0d", VEC[i].r, i));
    end
    rd(O_WDT, 32'h1234_0010, "R8 wdt readback");
    chk("R2 cop_rst_n", {31'b0, cop_rst_n}, 32'h1);
    chk("R11 tcm_cfg", {28'b0, tcm_cfg}, 32'h5);

    // R3: writing 0 does not clear, ack does
    wr(O_DB, 32'h0);
    rd(O_DB, 32'h1, "R3 write zero ignored");
    @(negedge clk) cop_ack = 1'b1;
    @(negedge clk) cop_ack = 1'b0;
    rd(O_DB, 32'h0, "R3 ack clears");
    chk("R3 db_pending", {31'b0, db_pending}, 32'h0);

    // R5 / R7: message cause
    @(negedge clk) cop_msg_req = 1'b1;
    @(negedge clk) cop_msg_req = 1'b0;
    rd(O_STAT, 32'h0000_0100, "R5 message cause");
    chk("R7 irq high", {31'b0, host_irq}, 32'h1);
    chk("R6 stat_busy", {31'b0, stat_busy}, 32'h1);
    wr(O_STAT, 32'h0);
    rd(O_STAT, 32'h0, "R6 clear by zero write");
    chk("R7 irq low", {31'b0, host_irq}, 32'h0);

    // R9: expiry on the (L+1)-th edge after enable, L = 5
    wr(O_WDT, 32'h0000_0005);
    wr(O_WDT, 32'h8000_0005);
    h_addr = O_STAT;
    repeat (5) @(negedge clk);
    #1 chk("R9 not yet expired", h_rdata, 32'h0);
    @(negedge clk);
    #1 chk("R9 expiry cause", h_rdata, 32'h0000_0001);
    chk("R7 irq on expiry", {31'b0, host_irq}, 32'h1);

    // R6: hold-off of message and further expiries
    @(negedge clk) cop_msg_req = 1'b1;
    @(negedge clk) cop_msg_req = 1'b0;
    rd(O_STAT, 32'h0000_0001, "R6 message held off");
    repeat (12) @(negedge clk);
    rd(O_STAT, 32'h0000_0001, "R6 second expiry dropped");
    wr(O_WDT, 32'h0000_0005);
    wr(O_STAT, 32'h0);
    repeat (12) @(negedge clk);
    rd(O_STAT, 32'h0, "R8 disabled counter quiet");

    // R9: kicks prevent expiry
    wr(O_WDT, 32'h8000_0005);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk) cop_wdt_kick = 1'b1;
      @(negedge clk) cop_wdt_kick = 1'b0;
      @(negedge clk);
    end
    rd(O_STAT, 32'h0, "R9 kick reloads");
    wr(O_WDT, 32'h0000_0005);

    // R4: dropping run clears doorbell, blocks causes
    wr(O_DB, 32'h1);
    rd(O_DB, 32'h1, "R3 doorbell set");
    wr(O_CTRL, 32'h0);
    rd(O_DB, 32'h0, "R4 run low clears doorbell");
    chk("R4 cop_rst_n", {31'b0, cop_rst_n}, 32'h0);
    wr(O_DB, 32'h1);
    rd(O_DB, 32'h0, "R4 doorbell set ignored");
    @(negedge clk) cop_msg_req = 1'b1;
    repeat (3) @(negedge clk);
    cop_msg_req = 1'b0;
    rd(O_STAT, 32'h0, "R4 message ignored");
    wr(O_WDT, 32'h8000_0002);
    repeat (10) @(negedge clk);
    rd(O_STAT, 32'h0, "R4 watchdog stopped");

    // R1: reset mid-run
    wr(O_TCM, 32'h7);
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(O_CTRL, 32'h0, "R1 run after reset");
    rd(O_TCM, 32'h2, "R1 split after reset");
    rd(O_WDT, 32'h0000_0040, "R1 wdt after reset");
    rd(O_STAT, 32'h0, "R1 status after reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule